// File: doc/BRIEF.md
# Single-Error-Correcting RAM with Read Scrubbing

This block is a single-clock memory with one write port and one read port. Every 64-bit word is kept with eight check bits, 72 bits in all. The check bits are generated on the way in. On the way out the word is decoded, a single flipped bit is repaired and two flipped bits are reported. The read port returns the repaired data together with two flags: one for a corrected word and one for a word that cannot be corrected.

The read path repairs only the copy it returns. The stored copy stays damaged until something rewrites it. For that reason, a corrected read automatically writes the repaired word back to its own address in the next cycle. This keeps contents that are read often but rarely written, such as lookup tables, from gathering a second upset. The write-back can be removed with a parameter. A test port flips chosen stored bits so that errors can be injected.

Top module: `ecc_scrub_ram`

## Requirements
- R1: The stored word uses the following bit layout. Bit 0 is an overall parity bit over all 72 bits. Bits 1, 2, 4, 8, 16, 32 and 64 are check bits. The 64 remaining positions hold data bits 0 to 63, in ascending order. A word written and then read back unchanged returns the same data with both error flags low.
- R2: `rd_valid` is high exactly in the cycle after a cycle with `rd_en` high. The data and both flags are valid in that same cycle. Both flags are low whenever `rd_valid` is low.
- R3: When exactly one stored data bit is flipped, the read returns the original data with `err_corr`=1 and `err_uncorr`=0.
- R4: When only a check bit or only the overall parity bit (bit 0) is flipped, the read reports `err_corr`=1 and returns the data unchanged.
- R5: When two stored bits of one word are flipped, the read reports `err_uncorr`=1 and `err_corr`=0. The two flags are never high together.
- R6: With `SCRUB`=1, in the cycle where a corrected read is presented, the repaired and fully re-encoded word is written back to the same address at the next clock edge. A later read of that address is then clean.
- R7: When a user write to the same address occurs in that write-back cycle, the user write takes priority and the write-back is dropped. A later read returns the user data.
- R8: When `inj_en` is high, the stored word at `inj_addr` is XORed with `inj_mask`. When a user write hits the same address at the same edge, the user write wins.
- R9: A read and a write to the same address at the same edge return the word held before that write.
- R10: While reset is asserted and after it is released, `rd_valid`, `err_corr` and `err_uncorr` are low until the first read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the read pipeline |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 64 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 64 | Corrected read data |
| rd_valid | output | 1 | Read data and flags are valid |
| err_corr | output | 1 | A single error was corrected |
| err_uncorr | output | 1 | A double error was detected |
| inj_en | input | 1 | Apply the injection mask |
| inj_addr | input | ADDR_W | Injection address |
| inj_mask | input | 72 | Bits of the stored word to flip |

## Verification
The bench builds the block with `ADDR_W`=4 and `SCRUB`=1. The small depth keeps the storage small while leaving separate addresses for each scenario. With `SCRUB` on, the bench can check the write-back, and also the case where a user write collides with it, directly at the ports. Injection masks are built from the bit layout in R1. This lets the bench aim flips at data, check and parity positions on purpose, and check corrected data against the values it wrote.

// File: rtl/ecc_scrub_ram.sv
module ecc_scrub_ram #(
  parameter int ADDR_W = 6,
  parameter bit SCRUB  = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [63:0]       wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [63:0]       rd_data,
  output logic              rd_valid,
  output logic              err_corr,
  output logic              err_uncorr,
  input  logic              inj_en,
  input  logic [ADDR_W-1:0] inj_addr,
  input  logic [71:0]       inj_mask
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CW    = 72;

  function automatic logic [CW-1:0] encode(input logic [63:0] d);
    logic [CW-1:0] c;
    logic [6:0]    s;
    int            k;
    c = '0;
    k = 0;
    for (int p = 1; p < CW; p++)
      if ((p & (p - 1)) != 0) begin
        c[p] = d[k];
        k++;
      end
    s = '0;
    for (int p = 1; p < CW; p++)
      if (c[p]) s ^= 7'(p);
    for (int b = 0; b < 7; b++) c[1 << b] = s[b];
    c[0] = ^c;
    return c;
  endfunction

  logic [CW-1:0]     mem [DEPTH];
  logic [CW-1:0]     raw_q;
  logic [ADDR_W-1:0] ra_q;
  logic [6:0]        syn;
  logic              par;
  logic [CW-1:0]     fixed;
  logic [63:0]       dout;
  logic              single, double;
  logic              wb_go;

  always_comb begin
    syn = '0;
    for (int p = 1; p < CW; p++)
      if (raw_q[p]) syn ^= 7'(p);
    par = ^raw_q;
    fixed = raw_q;
    if (par && syn != 7'd0 && syn < 7'd72) fixed[syn] = ~fixed[syn];
    dout = '0;
    begin
      int k;
      k = 0;
      for (int p = 1; p < CW; p++)
        if ((p & (p - 1)) != 0) begin
          dout[k] = fixed[p];
          k++;
        end
    end
  end

  assign single     = par && syn < 7'd72;
  assign double     = (!par && syn != 7'd0) || (par && syn >= 7'd72);
  assign rd_data    = dout;
  assign err_corr   = rd_valid && single;
  assign err_uncorr = rd_valid && double;
  assign wb_go      = SCRUB && err_corr && !(wr_en && wr_addr == ra_q);

  always_ff @(posedge clk) begin
    if (inj_en) mem[inj_addr] <= mem[inj_addr] ^ inj_mask;
    if (wb_go)  mem[ra_q]     <= encode(dout);
    if (wr_en)  mem[wr_addr]  <= encode(wr_data);
    if (rd_en) begin
      raw_q <= mem[rd_addr];
      ra_q  <= rd_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rd_valid <= 1'b0;
    else        rd_valid <= rd_en;
endmodule

module ecc_scrub_ram_chk #(
  parameter int ADDR_W = 6,
  parameter bit SCRUB  = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              rd_valid,
  input logic              err_corr,
  input logic              err_uncorr,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [ADDR_W-1:0] ra_q
);
  logic fix_seen;
  assign fix_seen = rd_valid && err_corr && !(wr_en && wr_addr == ra_q);

  // R2
  valid_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

  // R2
  flags_need_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> !err_corr && !err_uncorr);

  // R5
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({err_corr, err_uncorr}));

  // R6
  scrub_cleans_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (SCRUB && rd_valid && $past(fix_seen, 2) && $past(rd_addr) == $past(ra_q, 2))
      |-> !err_corr && !err_uncorr);
endmodule

bind ecc_scrub_ram ecc_scrub_ram_chk #(.ADDR_W(ADDR_W), .SCRUB(SCRUB)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
  .rd_valid(rd_valid), .err_corr(err_corr), .err_uncorr(err_uncorr),
  .wr_en(wr_en), .wr_addr(wr_addr), .ra_q(ra_q)
);

// File: tb/ecc_scrub_ram_bench.sv
`timescale 1ns/1ps
module ecc_scrub_ram_bench;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0, rd_en = 1'b0, inj_en = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0, inj_addr = '0;
  logic [63:0]   wr_data = '0;
  logic [71:0]   inj_mask = '0;
  logic [63:0]   rd_data;
  logic          rd_valid, err_corr, err_uncorr;
  int            total = 0, bad = 0;
  bit            done = 1'b0;

  ecc_scrub_ram #(.ADDR_W(AW), .SCRUB(1'b1)) u_ecc_scrub_ram (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
    .err_corr(err_corr), .err_uncorr(err_uncorr),
    .inj_en(inj_en), .inj_addr(inj_addr), .inj_mask(inj_mask)
  );

  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [63:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic inj(input logic [AW-1:0] a, input logic [71:0] m);
    @(negedge clk); inj_en = 1; inj_addr = a; inj_mask = m;
    @(negedge clk); inj_en = 0;
  endtask

  // leaves the caller at the negedge where the result is presented
  task automatic rd(input logic [AW-1:0] a);
    @(negedge clk); rd_en = 1; rd_addr = a;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic expect_rd(input string req, input logic [63:0] d, input logic c, input logic u);
    chk({req, " valid"}, 64'(rd_valid), 64'd1);
    chk({req, " data"}, rd_data, d);
    chk({req, " corr"}, 64'(err_corr), 64'(c));
    chk({req, " uncorr"}, 64'(err_uncorr), 64'(u));
  endtask

  task automatic t_reset;
    #1;
    chk("R10 in reset", {61'd0, rd_valid, err_corr, err_uncorr}, 64'd0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R10 after reset", {61'd0, rd_valid, err_corr, err_uncorr}, 64'd0);
  endtask

  task automatic t_clean;
    logic [63:0] pats [4] = '{64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hA5A5_5A5A_0123_4567, 64'h8000_0000_0000_0001};
    for (int i = 0; i < 4; i++) wr(AW'(i), pats[i]);
    for (int i = 0; i < 4; i++) begin
      rd(AW'(i));
      expect_rd("R1 clean", pats[i], 0, 0);
    end
    @(negedge clk);
    chk("R2 valid drops", 64'(rd_valid), 64'd0);
  endtask

  task automatic t_single_data;
    // position 3 holds data bit 0, position 71 holds data bit 63
    wr(4'd5, 64'hDEAD_BEEF_CAFE_F00D);
    inj(4'd5, 72'd1 << 3);
    rd(4'd5);
    expect_rd("R3 data bit", 64'hDEAD_BEEF_CAFE_F00D, 1, 0);
    wr(4'd6, 64'h1357_9BDF_2468_ACE0);
    inj(4'd6, 72'd1 << 71);
    rd(4'd6);
    expect_rd("R3 top bit", 64'h1357_9BDF_2468_ACE0, 1, 0);
  endtask

  task automatic t_check_par;
    wr(4'd7, 64'h0F0F_F0F0_3C3C_C3C3);
    inj(4'd7, 72'd1 << 16);
    rd(4'd7);
    expect_rd("R4 check bit", 64'h0F0F_F0F0_3C3C_C3C3, 1, 0);
    wr(4'd8, 64'h7777_0000_9999_1111);
    inj(4'd8, 72'd1);
    rd(4'd8);
    expect_rd("R4 parity bit", 64'h7777_0000_9999_1111, 1, 0);
  endtask

  task automatic t_double;
    wr(4'd9, 64'h0000_1111_2222_3333);
    inj(4'd9, (72'd1 << 5) | (72'd1 << 40));
    rd(4'd9);
    chk("R5 uncorr", 64'(err_uncorr), 64'd1);
    chk("R5 no corr", 64'(err_corr), 64'd0);
  endtask

  task automatic t_scrub;
    wr(4'd10, 64'h5555_AAAA_5555_AAAA);
    inj(4'd10, 72'd1 << 12);
    rd(4'd10);
    expect_rd("R6 first read", 64'h5555_AAAA_5555_AAAA, 1, 0);
    rd(4'd10);
    expect_rd("R6 after scrub", 64'h5555_AAAA_5555_AAAA, 0, 0);
    // word 8 was corrected earlier and must also be clean now
    rd(4'd8);
    expect_rd("R6 parity scrubbed", 64'h7777_0000_9999_1111, 0, 0);
  endtask

  task automatic t_collide;
    wr(4'd11, 64'h1111_1111_1111_1111);
    inj(4'd11, 72'd1 << 33);
    rd(4'd11);
    chk("R7 corr seen", 64'(err_corr), 64'd1);
    wr_en = 1; wr_addr = 4'd11; wr_data = 64'h2222_3333_4444_5555;
    @(negedge clk); wr_en = 0;
    rd(4'd11);
    expect_rd("R7 user write wins", 64'h2222_3333_4444_5555, 0, 0);
  endtask

  task automatic t_inject_vs_write;
    wr(4'd12, 64'hABCD_0000_0000_DCBA);
    @(negedge clk);
    inj_en = 1; inj_addr = 4'd12; inj_mask = (72'd1 << 6) | (72'd1 << 9);
    wr_en = 1; wr_addr = 4'd12; wr_data = 64'h0BAD_F00D_0BAD_F00D;
    @(negedge clk); inj_en = 0; wr_en = 0;
    rd(4'd12);
    expect_rd("R8 write beats inject", 64'h0BAD_F00D_0BAD_F00D, 0, 0);
  endtask

  task automatic t_rdw;
    wr(4'd13, 64'h0000_0000_CAFE_0001);
    @(negedge clk);
    rd_en = 1; rd_addr = 4'd13;
    wr_en = 1; wr_addr = 4'd13; wr_data = 64'h0000_0000_CAFE_0002;
    @(negedge clk); rd_en = 0; wr_en = 0;
    expect_rd("R9 old data", 64'h0000_0000_CAFE_0001, 0, 0);
    rd(4'd13);
    expect_rd("R9 new data", 64'h0000_0000_CAFE_0002, 0, 0);
  endtask

  initial begin
    t_reset();
    t_clean();
    t_single_data();
    t_check_par();
    t_double();
    t_scrub();
    t_collide();
    t_inject_vs_write();
    t_rdw();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule